// File: doc/BRIEF.md
# Flash Page-Program Write Engine

This block writes data into a serial NOR flash through a small register window. Software chooses a 24-bit target address by writing three address byte registers. It then either programs a single byte, or fills a 256-byte page buffer and programs the whole page with one trigger. The engine runs the full flash sequence by itself. It first sends a write-enable frame. It then sends a page-program frame that carries the address and the data. It then reads the flash status in repeated frames until the write-in-progress flag drops. Only after that does it clear the trigger bit, and software polls that bit to learn that the write is done.

The sequencer moves through these named states. `S_IDLE` goes to `S_WREN` when the trigger is set. `S_WREN` sends 0x06 and goes to `S_GAP1`. `S_GAP1` is a one-cycle chip-select high gap and goes to `S_PCMD`. `S_PCMD` sends 0x02 and goes to `S_PADDR`. `S_PADDR` sends three address bytes and goes to `S_PDATA`. `S_PDATA` sends one byte or a whole page and goes to `S_GAP2`. `S_GAP2` goes to `S_SCMD`. `S_SCMD` sends 0x05 and goes to `S_SREAD`. `S_SREAD` reads one byte. If bit 0 of that byte is 1 it goes to `S_GAP3` and from there back to `S_SCMD`. If bit 0 is 0 it goes to `S_FINISH`. `S_FINISH` clears the trigger and returns to `S_IDLE`.

The flash link is single-lane SPI mode 0. The serial clock runs at half the system clock.

Top module: `flash_page_writer`

## Requirements
- R1: Register selects 1, 2 and 3 hold address bits 7:0, 15:8 and 23:16 (from `reg_wdata[7:0]`). Each reads back the same byte on `reg_rdata[7:0]`.
- R2: Single-byte mode works as follows. Software writes a byte to select 4, then writes select 0 with bit 4 set. The engine then sends a one-byte frame 0x06. It then sends a frame made of 0x02, the three address bytes (most significant first) and that one data byte.
- R3: Bit 4 of select 0 reads 1 from the cycle after an accepted trigger until the sequence completes. After completion it reads 0.
- R4: After the program frame, the engine sends status frames: 0x05 followed by one read byte. It repeats them until the returned bit 0 is 0, and only then completes.
- R5: Bit 0 of select 6 set to 1 selects buffered mode. In buffered mode, each write to select 5 stores one 32-bit word, with bits 7:0 holding the lowest-addressed byte and bits 31:24 the highest. A trigger then sends all 256 page bytes in address order in one program frame.
- R6: The buffer word count (read on select 5) returns to 0 in two cases: when bit 0 of select 6 goes from 0 to 1, and after each buffered program. Unloaded words are sent as 0xFF bytes.
- R7: Bit 7 set together with the trigger in single-byte mode advances the stored address by one (modulo 2^24) after the byte. In buffered mode, or without bit 7, the address does not change.
- R8: While the trigger bit reads 1, every register write is ignored, including a new trigger.
- R9: Select 5 writes beyond 64 words, or made while buffered mode is off, are ignored. The word count never exceeds 64.
- R10: After reset all registers read 0, chip select is high and the serial clock is low.
- R11: The serial clock is low when idle and pulses only while chip select is low. MOSI is sent most significant bit first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| flash_cs_n | output | 1 | Flash chip select, active low |
| flash_sck | output | 1 | Flash serial clock |
| flash_mosi | output | 1 | Serial data to the flash |
| flash_miso | input | 1 | Serial data from the flash |

## Verification
Two things can land in one cycle: completion of a program, which clears the trigger and resets the buffer count, and a fresh trigger write from software. The bench provokes this by writing the trigger on every cycle while the trigger reads 1, and it stops only once the bit reads 0. The flash model must then see exactly one extra program frame, and the address and mode written during the busy window must be unchanged afterwards.

// File: rtl/fpw_pkg.sv
package fpw_pkg;
    localparam int SEL_W      = 3;
    localparam int ADDR_BYTES = 3;
    localparam int ADDR_W     = ADDR_BYTES * 8;

    localparam logic [SEL_W-1:0] SEL_CMD  = 3'd0;
    localparam logic [SEL_W-1:0] SEL_A0   = 3'd1;
    localparam logic [SEL_W-1:0] SEL_A1   = 3'd2;
    localparam logic [SEL_W-1:0] SEL_A2   = 3'd3;
    localparam logic [SEL_W-1:0] SEL_BYTE = 3'd4;
    localparam logic [SEL_W-1:0] SEL_PAGE = 3'd5;
    localparam logic [SEL_W-1:0] SEL_CFG  = 3'd6;

    localparam int TRIG_BIT = 4;
    localparam int INC_BIT  = 7;
    localparam int BUF_BIT  = 0;

    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_PROG = 8'h02;
    localparam logic [7:0] OP_STAT = 8'h05;
    localparam logic [7:0] FILL    = 8'hFF;

    typedef enum logic [3:0] {
        S_IDLE, S_WREN, S_GAP1, S_PCMD, S_PADDR, S_PDATA,
        S_GAP2, S_SCMD, S_SREAD, S_GAP3, S_FINISH
    } fpw_state_e;
endpackage

// File: rtl/fpw_shifter.sv
module fpw_shifter #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [BITS-1:0] tx_byte,
    output logic            busy,
    output logic            done,
    output logic            sck,
    output logic            mosi
);
    localparam int PH_W = $clog2(2 * BITS);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(2 * BITS - 1);

    logic [PH_W-1:0] ph_q;
    logic [BITS-1:0] tx_q;
    logic            busy_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= '0;
            tx_q   <= '0;
            busy_q <= 1'b0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                tx_q   <= tx_byte;
                ph_q   <= '0;
            end
        end else begin
            ph_q <= ph_q + 1'b1;
            if (ph_q[0]) begin
                tx_q <= {tx_q[BITS-2:0], 1'b0};
            end
            if (ph_q == PH_LAST) begin
                busy_q <= 1'b0;
            end
        end
    end

    assign busy = busy_q;
    assign done = busy_q && (ph_q == PH_LAST);
    assign sck  = busy_q && ph_q[0];
    assign mosi = busy_q && tx_q[BITS-1];

    // R11: the sequencer never launches a byte over one in flight
    assert_no_start_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> !start);
endmodule

// File: rtl/fpw_regs.sv
module fpw_regs
    import fpw_pkg::*;
#(
    parameter int PAGE_BYTES = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [$clog2(PAGE_BYTES)-1:0] byte_idx,
    input  logic              finish,
    output logic              trig,
    output logic              buf_mode,
    output logic [ADDR_W-1:0] addr,
    output logic [7:0]        data_byte
);
    localparam int WORDS  = PAGE_BYTES / 4;
    localparam int IDX_W  = $clog2(PAGE_BYTES);
    localparam int WIDX_W = $clog2(WORDS);
    localparam int PTR_W  = $clog2(WORDS + 1);
    localparam logic [PTR_W-1:0] PTR_FULL = PTR_W'(WORDS);

    logic              trig_q, inc_q, buf_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        byte_q;
    logic [PTR_W-1:0]  ptr_q;
    logic [31:0]       page_q [WORDS];

    logic wr_ok, page_we;
    assign wr_ok   = reg_wr && !trig_q;
    assign page_we = wr_ok && (reg_sel == SEL_PAGE) && buf_q && (ptr_q < PTR_FULL);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q <= 1'b0;
            inc_q  <= 1'b0;
            buf_q  <= 1'b0;
            addr_q <= '0;
            byte_q <= '0;
            ptr_q  <= '0;
        end else if (finish) begin
            trig_q <= 1'b0;
            inc_q  <= 1'b0;
            if (!buf_q && inc_q) begin
                addr_q <= addr_q + 1'b1;
            end
            if (buf_q) begin
                ptr_q <= '0;
            end
        end else if (wr_ok) begin
            case (reg_sel)
                SEL_CMD: begin
                    if (reg_wdata[TRIG_BIT]) begin
                        trig_q <= 1'b1;
                        inc_q  <= reg_wdata[INC_BIT];
                    end
                end
                SEL_A0:   addr_q[7:0]   <= reg_wdata[7:0];
                SEL_A1:   addr_q[15:8]  <= reg_wdata[7:0];
                SEL_A2:   addr_q[23:16] <= reg_wdata[7:0];
                SEL_BYTE: byte_q        <= reg_wdata[7:0];
                SEL_PAGE: begin
                    if (page_we) begin
                        ptr_q <= ptr_q + 1'b1;
                    end
                end
                SEL_CFG: begin
                    buf_q <= reg_wdata[BUF_BIT];
                    if (reg_wdata[BUF_BIT] && !buf_q) begin
                        ptr_q <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (page_we) begin
            page_q[ptr_q[WIDX_W-1:0]] <= reg_wdata;
        end
    end

    logic [WIDX_W-1:0] rd_widx;
    logic [31:0]       rd_word;
    logic              rd_loaded;
    logic [7:0]        lane_byte;

    assign rd_widx   = byte_idx[IDX_W-1:2];
    assign rd_word   = page_q[rd_widx];
    assign rd_loaded = PTR_W'(rd_widx) < ptr_q;

    always_comb begin
        case (byte_idx[1:0])
            2'd0:    lane_byte = rd_word[7:0];
            2'd1:    lane_byte = rd_word[15:8];
            2'd2:    lane_byte = rd_word[23:16];
            default: lane_byte = rd_word[31:24];
        endcase
        if (!buf_q) begin
            data_byte = byte_q;
        end else if (rd_loaded) begin
            data_byte = lane_byte;
        end else begin
            data_byte = FILL;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_CMD: begin
                reg_rdata[TRIG_BIT] = trig_q;
                reg_rdata[INC_BIT]  = inc_q;
            end
            SEL_A0:   reg_rdata[7:0]  = addr_q[7:0];
            SEL_A1:   reg_rdata[7:0]  = addr_q[15:8];
            SEL_A2:   reg_rdata[7:0]  = addr_q[23:16];
            SEL_BYTE: reg_rdata[7:0]  = byte_q;
            SEL_PAGE: reg_rdata       = 32'(ptr_q);
            SEL_CFG:  reg_rdata[BUF_BIT] = buf_q;
            default:  reg_rdata = '0;
        endcase
    end

    assign trig     = trig_q;
    assign buf_mode = buf_q;
    assign addr     = addr_q;

    // R8: a write arriving mid-sequence leaves state untouched
    assert_busy_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_q && reg_wr && !finish) |=> ($stable(addr_q) && $stable(buf_q) && trig_q));
    // R9: the word count is bounded by the page size
    assert_ptr_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= PTR_FULL);
    // R6: a finished page empties the buffer count
    assert_page_ptr_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && buf_q) |=> (ptr_q == '0));
    // R7: buffered completion never moves the address
    assert_buf_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && buf_q) |=> $stable(addr_q));
endmodule

// File: rtl/fpw_seq.sv
module fpw_seq
    import fpw_pkg::*;
#(
    parameter int PAGE_BYTES = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              buf_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data_byte,
    input  logic              sh_busy,
    input  logic              sh_done,
    input  logic              flash_miso,
    output logic              cs_n,
    output logic              sh_start,
    output logic [7:0]        tx_byte,
    output logic [$clog2(PAGE_BYTES)-1:0] byte_idx,
    output logic              finish
);
    localparam int IDX_W = $clog2(PAGE_BYTES);
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(PAGE_BYTES - 1);
    localparam logic [IDX_W-1:0] ADDR_LAST = IDX_W'(ADDR_BYTES - 1);

    fpw_state_e       state, nxt;
    logic [IDX_W-1:0] bcnt, bcnt_nxt;
    logic             last_data;

    assign last_data = !buf_mode || (bcnt == IDX_LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            bcnt  <= '0;
        end else begin
            state <= nxt;
            bcnt  <= bcnt_nxt;
        end
    end

    always_comb begin
        nxt      = state;
        bcnt_nxt = bcnt;
        unique case (state)
            S_IDLE:   if (go) nxt = S_WREN;
            S_WREN:   if (sh_done) nxt = S_GAP1;
            S_GAP1:   nxt = S_PCMD;
            S_PCMD: begin
                if (sh_done) begin
                    nxt      = S_PADDR;
                    bcnt_nxt = '0;
                end
            end
            S_PADDR: begin
                if (sh_done) begin
                    if (bcnt == ADDR_LAST) begin
                        nxt      = S_PDATA;
                        bcnt_nxt = '0;
                    end else begin
                        bcnt_nxt = bcnt + 1'b1;
                    end
                end
            end
            S_PDATA: begin
                if (sh_done) begin
                    if (last_data) begin
                        nxt      = S_GAP2;
                        bcnt_nxt = '0;
                    end else begin
                        bcnt_nxt = bcnt + 1'b1;
                    end
                end
            end
            S_GAP2:   nxt = S_SCMD;
            S_SCMD:   if (sh_done) nxt = S_SREAD;
            S_SREAD:  if (sh_done) nxt = flash_miso ? S_GAP3 : S_FINISH;
            S_GAP3:   nxt = S_SCMD;
            S_FINISH: nxt = S_IDLE;
        endcase
    end

    always_comb begin
        cs_n    = 1'b1;
        tx_byte = 8'h00;
        finish  = 1'b0;
        unique case (state)
            S_WREN: begin
                cs_n    = 1'b0;
                tx_byte = OP_WREN;
            end
            S_PCMD: begin
                cs_n    = 1'b0;
                tx_byte = OP_PROG;
            end
            S_PADDR: begin
                cs_n = 1'b0;
                for (int k = 0; k < ADDR_BYTES; k++) begin
                    if (bcnt == IDX_W'(ADDR_BYTES - 1 - k)) begin
                        tx_byte = addr[8*k +: 8];
                    end
                end
            end
            S_PDATA: begin
                cs_n    = 1'b0;
                tx_byte = data_byte;
            end
            S_SCMD: begin
                cs_n    = 1'b0;
                tx_byte = OP_STAT;
            end
            S_SREAD: begin
                cs_n    = 1'b0;
                tx_byte = 8'h00;
            end
            S_FINISH: finish = 1'b1;
            S_IDLE, S_GAP1, S_GAP2, S_GAP3: ;
        endcase
        sh_start = !cs_n && !sh_busy;
    end

    assign byte_idx = bcnt;

    // R3: the sequencer is only active while the trigger is held
    assert_trig_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |-> go);
    // R4: completion only after a status byte with bit 0 clear
    assert_finish_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        finish |-> ($past(sh_done) && !$past(flash_miso)));
endmodule

// File: rtl/flash_page_writer.sv
module flash_page_writer
    import fpw_pkg::*;
#(
    parameter int PAGE_BYTES = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             flash_cs_n,
    output logic             flash_sck,
    output logic             flash_mosi,
    input  logic             flash_miso
);
    localparam int IDX_W = $clog2(PAGE_BYTES);

    logic              trig, buf_mode, finish;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        data_byte, tx_byte;
    logic [IDX_W-1:0]  byte_idx;
    logic              sh_start, sh_busy, sh_done;

    fpw_regs #(.PAGE_BYTES(PAGE_BYTES)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .byte_idx  (byte_idx),
        .finish    (finish),
        .trig      (trig),
        .buf_mode  (buf_mode),
        .addr      (addr),
        .data_byte (data_byte)
    );

    fpw_seq #(.PAGE_BYTES(PAGE_BYTES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (trig),
        .buf_mode   (buf_mode),
        .addr       (addr),
        .data_byte  (data_byte),
        .sh_busy    (sh_busy),
        .sh_done    (sh_done),
        .flash_miso (flash_miso),
        .cs_n       (flash_cs_n),
        .sh_start   (sh_start),
        .tx_byte    (tx_byte),
        .byte_idx   (byte_idx),
        .finish     (finish)
    );

    fpw_shifter #(.BITS(8)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (sh_start),
        .tx_byte (tx_byte),
        .busy    (sh_busy),
        .done    (sh_done),
        .sck     (flash_sck),
        .mosi    (flash_mosi)
    );

    // R11: serial clock pulses only inside a selected frame
    assert_sck_framed_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flash_sck |-> !flash_cs_n);
endmodule

// File: tb/sim_flash_page_writer.sv
`timescale 1ns/1ps
module sim_flash_page_writer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        flash_cs_n, flash_sck, flash_mosi, flash_miso;

    always #2 clk = ~clk;

    flash_page_writer #(.PAGE_BYTES(256)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .flash_cs_n(flash_cs_n),
        .flash_sck(flash_sck), .flash_mosi(flash_mosi), .flash_miso(flash_miso)
    );

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    // ---------------- flash model ----------------
    logic [7:0]  fmem [0:1023];
    logic [7:0]  sh = 8'd0, op = 8'd0, bnew, sout = 8'd0;
    logic [23:0] pa = 24'd0, tgt;
    int bitc = 0, bytec = 0, wip_left = 0;
    int n_wren = 0, n_prog = 0, n_stat = 0, last_len = 0;
    int prog_no_wel = 0, wren_bad = 0, sck_viol = 0;
    bit wel = 1'b0, skip = 1'b0;

    assign flash_miso = sout[7];

    always @(negedge flash_cs_n) begin
        bitc = 0;
        bytec = 0;
    end

    always @(posedge flash_cs_n) begin
        if (bytec > 0) begin
            if (op == 8'h06) begin
                n_wren++;
                wel = 1'b1;
                if (bytec != 1) wren_bad++;
            end else if (op == 8'h02 && bytec >= 4) begin
                n_prog++;
                last_len = bytec - 4;
                if (!wel) prog_no_wel++;
                wel = 1'b0;
                wip_left = 3;
            end else if (op == 8'h05) begin
                n_stat++;
                if (wip_left > 0) wip_left--;
            end
        end
    end

    always @(posedge flash_sck) begin
        if (!flash_cs_n) begin
            bnew = {sh[6:0], flash_mosi};
            sh = bnew;
            bitc++;
            if (bitc == 8) begin
                bitc = 0;
                if (bytec == 0) begin
                    op = bnew;
                    if (bnew == 8'h05) begin
                        sout = {7'd0, (wip_left > 0)};
                        skip = 1'b1;
                    end
                end else if (op == 8'h02) begin
                    if (bytec <= 3) begin
                        pa = {pa[15:0], bnew};
                    end else begin
                        tgt = pa + 24'(bytec - 4);
                        fmem[tgt[9:0]] = bnew;
                    end
                end
                bytec++;
            end
        end
    end

    always @(negedge flash_sck) begin
        if (skip) skip = 1'b0;
        else sout = {sout[6:0], 1'b0};
    end

    always @(negedge clk) begin
        if (flash_sck && flash_cs_n) sck_viol++;
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [31:0] d);
        @(negedge clk);
        reg_sel = sel;
        #1 d = reg_rdata;
    endtask

    task automatic set_addr(input logic [23:0] a);
        wr(3'd1, {24'd0, a[7:0]});
        wr(3'd2, {24'd0, a[15:8]});
        wr(3'd3, {24'd0, a[23:16]});
    endtask

    task automatic get_addr(output logic [23:0] a);
        logic [31:0] d;
        rd(3'd1, d); a[7:0] = d[7:0];
        rd(3'd2, d); a[15:8] = d[7:0];
        rd(3'd3, d); a[23:16] = d[7:0];
    endtask

    task automatic wait_idle();
        logic [31:0] d;
        int n = 0;
        do begin
            rd(3'd0, d);
            n++;
        end while (d[4] && n < 40000);
    endtask

    function automatic logic [7:0] pat(input int k);
        return 8'(k) ^ 8'h96;
    endfunction

    // {autoinc, address, data}
    localparam logic [32:0] VEC [0:4] = '{
        {1'b0, 24'h000010, 8'hA5},
        {1'b1, 24'h000020, 8'h3C},
        {1'b1, 24'h0003FF, 8'h5A},
        {1'b1, 24'hFFFFFF, 8'h77},
        {1'b0, 24'h000040, 8'hC3}
    };

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [23:0] a;
        int p0, w0, s0, bad;
        for (int i = 0; i < 1024; i++) fmem[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        for (int s = 0; s < 7; s++) begin
            rd(3'(s), d);
            chk("R10 register reset", d, 32'd0);
        end
        chk("R10 cs_n idle high", {31'd0, flash_cs_n}, 32'd1);
        chk("R10 sck idle low", {31'd0, flash_sck}, 32'd0);

        // table of single-byte programs: R1 R2 R3 R4 R7
        for (int i = 0; i < 5; i++) begin
            logic        inc;
            logic [23:0] va;
            logic [7:0]  vd;
            inc = VEC[i][32]; va = VEC[i][31:8]; vd = VEC[i][7:0];
            p0 = n_prog; w0 = n_wren; s0 = n_stat;
            set_addr(va);
            get_addr(a);
            chk("R1 address readback", {8'd0, a}, {8'd0, va});
            wr(3'd4, {24'd0, vd});
            wr(3'd0, {24'd0, inc, 2'b00, 1'b1, 4'b0000});
            rd(3'd0, d);
            chk("R3 trigger held while busy", {31'd0, d[4]}, 32'd1);
            wait_idle();
            rd(3'd0, d);
            chk("R3 trigger cleared", {31'd0, d[4]}, 32'd0);
            chk("R2 byte programmed", {24'd0, fmem[va[9:0]]}, {24'd0, vd});
            chk("R2 one program frame", n_prog - p0, 1);
            chk("R2 one write-enable frame", n_wren - w0, 1);
            chk("R2 program frame length", last_len, 1);
            chk("R4 status polled until ready", n_stat - s0, 4);
            get_addr(a);
            chk("R7 address after program", {8'd0, a}, {8'd0, inc ? va + 24'd1 : va});
        end
        chk("R2 write-enable precedes program", prog_no_wel, 0);

        // R5 full buffered page, bit 7 set but no address advance (R7)
        wr(3'd6, 32'd1);
        for (int w = 0; w < 64; w++)
            wr(3'd5, {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)});
        rd(3'd5, d);
        chk("R6 word count after fill", d, 32'd64);
        set_addr(24'h000100);
        wr(3'd0, 32'h90);
        wait_idle();
        bad = 0;
        for (int k = 0; k < 256; k++) if (fmem[10'h100 + k] !== pat(k)) bad++;
        chk("R5 page bytes in lane order", bad, 0);
        chk("R5 page frame length", last_len, 256);
        rd(3'd5, d);
        chk("R6 count cleared after page", d, 32'd0);
        get_addr(a);
        chk("R7 buffered mode keeps address", {8'd0, a}, 32'h100);

        // R6 enable edge resets count, partial page fills with 0xFF
        for (int w = 0; w < 5; w++) wr(3'd5, 32'h0);
        wr(3'd6, 32'd0);
        rd(3'd5, d);
        chk("R6 count kept on disable", d, 32'd5);
        wr(3'd6, 32'd1);
        rd(3'd5, d);
        chk("R6 count reset on enable", d, 32'd0);
        wr(3'd5, 32'h44332211);
        wr(3'd5, 32'h88776655);
        set_addr(24'h000200);
        wr(3'd0, 32'h10);
        wait_idle();
        bad = 0;
        for (int k = 0; k < 8; k++) if (fmem[10'h200 + k] !== 8'(8'h11 * (k + 1))) bad++;
        chk("R5 partial loaded bytes", bad, 0);
        bad = 0;
        for (int k = 8; k < 256; k++) if (fmem[10'h200 + k] !== 8'hFF) bad++;
        chk("R6 unloaded bytes sent as FF", bad, 0);

        // R9 overflow and single-mode page writes ignored
        wr(3'd6, 32'd0);
        wr(3'd5, 32'hDEADBEEF);
        rd(3'd5, d);
        chk("R9 page port ignored in single mode", d, 32'd0);
        wr(3'd6, 32'd1);
        for (int w = 0; w < 66; w++) wr(3'd5, w);
        rd(3'd5, d);
        chk("R9 count saturates at 64", d, 32'd64);

        // R8 writes during busy, trigger hammered through completion
        wr(3'd6, 32'd0);
        set_addr(24'h000300);
        wr(3'd4, 32'hE1);
        p0 = n_prog;
        wr(3'd0, 32'h10);
        wr(3'd1, 32'hAA);
        wr(3'd6, 32'd1);
        wr(3'd4, 32'h12);
        do begin
            @(negedge clk);
            reg_sel = 3'd0;
            reg_wdata = 32'h10;
            #1 d = reg_rdata;
            reg_wr = d[4];
        end while (d[4]);
        reg_wr = 1'b0;
        repeat (20) @(negedge clk);
        chk("R8 exactly one program under hammer", n_prog - p0, 1);
        rd(3'd0, d);
        chk("R8 retrigger not latched", {31'd0, d[4]}, 32'd0);
        get_addr(a);
        chk("R8 address write ignored", {8'd0, a}, 32'h300);
        rd(3'd6, d);
        chk("R8 config write ignored", d, 32'd0);
        chk("R8 data write ignored", {24'd0, fmem[10'h300]}, 32'hE1);

        // R11 framing
        chk("R11 sck only inside frame", sck_viol, 0);
        chk("R11 write-enable frame is one byte", wren_bad, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule